// File: doc/BRIEF.md
# Dual-Modulus Feedback Divider

This block divides a fast clock by a programmable integer N and emits one single-cycle pulse per N input clocks. It sits in the feedback path of a frequency synthesizer loop. A prescaler divides the fast clock by P or by P+1, and two counters that count prescaler periods choose between the two. The swallow count A sets how many prescaler periods use P+1. The main count B sets how many prescaler periods make up one output period.

The prescaler has two modes. In fixed mode it always divides by P. In dual-modulus mode it switches between P and P+1. Setting B to 1 bypasses the counters, and the overall ratio is then P. A combinational flag marks any configuration the rules do not allow, and the divider stays quiet while that flag is high. A level-held counter reset and a sync request (which needs its own enable) clear the counters. Counting starts again from zero when they are released. The asynchronous reset is released synchronously inside the block.

Top module: `fbdiv_top`

## Requirements
- R1: `cfg_psel_i` selects P: code 0→1, 1→2, 2→3, 3→4, 4→8, 5→16, 6→32, and code 7 is reserved (illegal). With `cfg_b_i` = 1 (bypass) and `cfg_a_i` = 0, the pulse spacing is P clocks in either mode.
- R2: With `cfg_dm_i` = 1, legal P codes are 1, 3, 4, 5, 6 (pairs 2/3, 4/5, 8/9, 16/17, 32/33). The spacing is N = P·B + A: P+1 for the first A prescaler periods and P for the rest.
- R3: With `cfg_dm_i` = 0 and B ≥ 3, the spacing is N = P·B, and `cfg_a_i` has no effect on it.
- R4: In dual-modulus mode, A = 0 means no P+1 periods, so N = P·B. Equivalent settings that give the same N produce the same spacing.
- R5: In dual-modulus mode with B ≥ 3, A ≥ B raises `cfg_bad_o`.
- R6: B = 0, B = 2, code 7, and codes 0 or 2 in dual-modulus mode each raise `cfg_bad_o`.
- R7: B = 1 with A ≠ 0 raises `cfg_bad_o`.
- R8: While `cfg_bad_o` is high no pulse is emitted. Once the configuration is legal again, the first pulse comes N clocks after it.
- R9: While `srst_i` is held high no pulse is emitted. The first pulse is seen N clocks after release.
- R10: `sync_req_i` clears the counters only when `sync_en_i` = 1. With the enable low, the pulse spacing is undisturbed.
- R11: After the asynchronous reset, `div_pulse_o` is low.
- R12: For N > 1 each pulse is exactly one clock wide and pulses repeat every N clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast input clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| srst_i | input | 1 | Level-held counter reset |
| sync_req_i | input | 1 | Sync reset request |
| sync_en_i | input | 1 | Enable for sync reset request |
| cfg_dm_i | input | 1 | 1 = dual-modulus, 0 = fixed divide |
| cfg_psel_i | input | 3 | Prescaler ratio code |
| cfg_a_i | input | A_W | Swallow count A |
| cfg_b_i | input | B_W | Main count B (1 = bypass) |
| div_pulse_o | output | 1 | One-cycle pulse per N clocks |
| cfg_bad_o | output | 1 | Illegal configuration flag |

## Verification
If the prescaler or the swallow counter holds a wrong value, the next pulse shows up at the wrong time. The spacing is off by a multiple of 1 for a swallow error, or by a multiple of P for a main-count error. This is seen within one output period, so every spacing check catches it, including the first pulse after a clear. A clear path that fails to zero the state shows up as a first pulse earlier than N clocks after release. Equivalent settings that give the same N separate a wrong P+1 selection from a wrong B wrap.

// File: rtl/fbdiv_pkg.sv
package fbdiv_pkg;
  localparam int PW = 6;

  typedef enum logic [2:0] {
    PS_1    = 3'd0,
    PS_2    = 3'd1,
    PS_3    = 3'd2,
    PS_4    = 3'd3,
    PS_8    = 3'd4,
    PS_16   = 3'd5,
    PS_32   = 3'd6,
    PS_RSVD = 3'd7
  } psel_e;

  function automatic logic [PW-1:0] ps_ratio(input psel_e code);
    case (code)
      PS_1:    ps_ratio = 6'd1;
      PS_2:    ps_ratio = 6'd2;
      PS_3:    ps_ratio = 6'd3;
      PS_4:    ps_ratio = 6'd4;
      PS_8:    ps_ratio = 6'd8;
      PS_16:   ps_ratio = 6'd16;
      PS_32:   ps_ratio = 6'd32;
      default: ps_ratio = 6'd1;
    endcase
  endfunction
endpackage

// File: rtl/fbdiv_cfg.sv
module fbdiv_cfg
  import fbdiv_pkg::*;
#(
  parameter int A_W = 6,
  parameter int B_W = 13
) (
  input  logic           dm_i,
  input  logic [2:0]     psel_i,
  input  logic [A_W-1:0] a_i,
  input  logic [B_W-1:0] b_i,
  output logic [PW-1:0]  ratio_o,
  output logic           bypass_o,
  output logic           bad_o
);
  psel_e code;
  logic  code_bad, b_bad, a_bad;

  always_comb begin
    code     = psel_e'(psel_i);
    ratio_o  = ps_ratio(code);
    bypass_o = (b_i == B_W'(1));
    code_bad = (code == PS_RSVD) || (dm_i && ((code == PS_1) || (code == PS_3)));
    b_bad    = (b_i == '0) || (b_i == B_W'(2));
    if (bypass_o)  a_bad = (a_i != '0);
    else if (dm_i) a_bad = (32'(a_i) >= 32'(b_i));
    else           a_bad = 1'b0;
    bad_o    = code_bad || b_bad || a_bad;
  end
endmodule

// File: rtl/fbdiv_prescaler.sv
module fbdiv_prescaler #(
  parameter int PW = 6
) (
  input  logic          clk_i,
  input  logic          rst_n,
  input  logic          clear_i,
  input  logic [PW-1:0] ratio_i,
  input  logic          plus1_i,
  output logic          tick_o
);
  logic [PW-1:0] pc_q, pc_d, mod_w;

  always_comb begin
    mod_w  = ratio_i + {{(PW-1){1'b0}}, plus1_i};
    tick_o = (pc_q >= mod_w - PW'(1));
    if (clear_i)     pc_d = '0;
    else if (tick_o) pc_d = '0;
    else             pc_d = pc_q + PW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end

  p_clear_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_n)
    clear_i |=> (pc_q == '0));
  p_tick_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_n)
    tick_o && !clear_i |=> (pc_q == '0));
endmodule

// File: rtl/fbdiv_swallow.sv
module fbdiv_swallow #(
  parameter int A_W = 6,
  parameter int B_W = 13
) (
  input  logic           clk_i,
  input  logic           rst_n,
  input  logic           clear_i,
  input  logic           tick_i,
  input  logic           dm_i,
  input  logic           bypass_i,
  input  logic [A_W-1:0] a_i,
  input  logic [B_W-1:0] b_i,
  output logic           plus1_o,
  output logic           last_o
);
  logic [B_W-1:0] bcnt_q, bcnt_d;

  always_comb begin
    plus1_o = dm_i && !bypass_i && (32'(bcnt_q) < 32'(a_i));
    last_o  = bypass_i || (bcnt_q >= b_i - B_W'(1));
    if (clear_i)                bcnt_d = '0;
    else if (tick_i && last_o)  bcnt_d = '0;
    else if (tick_i)            bcnt_d = bcnt_q + B_W'(1);
    else                        bcnt_d = bcnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) bcnt_q <= '0;
    else        bcnt_q <= bcnt_d;
  end

  p_bcnt_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_n)
    !tick_i && !clear_i |=> $stable(bcnt_q));
endmodule

// File: rtl/fbdiv_top.sv
module fbdiv_top
  import fbdiv_pkg::*;
#(
  parameter int A_W = 6,
  parameter int B_W = 13
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           srst_i,
  input  logic           sync_req_i,
  input  logic           sync_en_i,
  input  logic           cfg_dm_i,
  input  logic [2:0]     cfg_psel_i,
  input  logic [A_W-1:0] cfg_a_i,
  input  logic [B_W-1:0] cfg_b_i,
  output logic           div_pulse_o,
  output logic           cfg_bad_o
);
  logic [1:0]    rst_sync_q;
  logic          rst_n;
  logic [PW-1:0] ratio_w;
  logic          bypass_w, clear_w, plus1_w, tick_w, last_w, pulse_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  fbdiv_cfg #(.A_W(A_W), .B_W(B_W)) u_cfg (
    .dm_i(cfg_dm_i), .psel_i(cfg_psel_i), .a_i(cfg_a_i), .b_i(cfg_b_i),
    .ratio_o(ratio_w), .bypass_o(bypass_w), .bad_o(cfg_bad_o)
  );

  assign clear_w = srst_i || (sync_en_i && sync_req_i) || cfg_bad_o;

  fbdiv_prescaler #(.PW(PW)) u_pre (
    .clk_i(clk_i), .rst_n(rst_n), .clear_i(clear_w), .ratio_i(ratio_w),
    .plus1_i(plus1_w), .tick_o(tick_w)
  );

  fbdiv_swallow #(.A_W(A_W), .B_W(B_W)) u_swl (
    .clk_i(clk_i), .rst_n(rst_n), .clear_i(clear_w), .tick_i(tick_w),
    .dm_i(cfg_dm_i), .bypass_i(bypass_w), .a_i(cfg_a_i), .b_i(cfg_b_i),
    .plus1_o(plus1_w), .last_o(last_w)
  );

  always_comb pulse_d = tick_w && last_w && !clear_w;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) div_pulse_o <= 1'b0;
    else        div_pulse_o <= pulse_d;
  end

  p_fd_no_plus1_r3: assert property (@(posedge clk_i) disable iff (!rst_n)
    !cfg_dm_i |-> !plus1_w);
  p_bypass_a_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
    (cfg_b_i == B_W'(1)) && (cfg_a_i != '0) |-> cfg_bad_o);
  p_bad_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
    cfg_bad_o |=> !div_pulse_o);
  p_srst_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_n)
    srst_i |=> !div_pulse_o);
  p_sync_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_n)
    sync_en_i && sync_req_i |=> !div_pulse_o);
  p_pulse_narrow_r12: assert property (@(posedge clk_i) disable iff (!rst_n)
    div_pulse_o && !bypass_w |=> !div_pulse_o);
endmodule

// File: tb/fbdiv_top_tb.sv
module fbdiv_top_tb;
  localparam int A_W = 6;
  localparam int B_W = 13;

  logic clk = 1'b0;
  logic rst_ni, srst, sreq, sen, dm;
  logic [2:0] psel;
  logic [A_W-1:0] a;
  logic [B_W-1:0] b;
  logic pulse, bad;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  fbdiv_top #(.A_W(A_W), .B_W(B_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .srst_i(srst), .sync_req_i(sreq),
    .sync_en_i(sen), .cfg_dm_i(dm), .cfg_psel_i(psel), .cfg_a_i(a),
    .cfg_b_i(b), .div_pulse_o(pulse), .cfg_bad_o(bad)
  );

  function automatic int p_of(int code);
    int t[7] = '{1, 2, 3, 4, 8, 16, 32};
    return (code < 7) ? t[code] : 0;
  endfunction

  function automatic int exp_n(bit m, int code, int av, int bv);
    int p;
    if (code > 6) return 0;
    if (m && (code == 0 || code == 2)) return 0;
    p = p_of(code);
    if (bv == 0 || bv == 2) return 0;
    if (bv == 1) return (av == 0) ? p : 0;
    if (m) return (av < bv) ? p * bv + av : 0;
    return p * bv;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // count clocks until the next pulse, starting at a negedge
  task automatic gap(int lim, output int cnt);
    cnt = 0;
    while (cnt < lim) begin
      @(posedge clk); cnt++;
      @(negedge clk);
      if (pulse) break;
    end
  endtask

  task automatic quiet(int cyc, string req);
    int seen = 0;
    repeat (cyc) begin
      @(negedge clk);
      if (pulse) seen++;
    end
    chk(seen == 0, req, seen, 0);
  endtask

  task automatic run_cfg(bit m, int code, int av, int bv, string req);
    int n, c;
    @(negedge clk);
    srst = 1; dm = m; psel = 3'(code); a = A_W'(av); b = B_W'(bv);
    @(negedge clk);
    n = exp_n(m, code, av, bv);
    chk(bad == (n == 0), {req, " flag"}, bad, n == 0);
    srst = 0;
    if (n == 0) begin
      quiet(60, {req, " R8 illegal quiet"});
    end else begin
      gap(n + 4, c); chk(c == n, {req, " first"}, c, n);
      gap(n + 4, c); chk(c == n, {req, " spacing"}, c, n);
      gap(n + 4, c); chk(c == n, {req, " spacing"}, c, n);
    end
    srst = 1;
  endtask

  initial begin
    #1900000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int c;
    void'($urandom(32'd20517));
    rst_ni = 0; srst = 1; sreq = 0; sen = 0; dm = 0; psel = 3'd0; a = '0; b = B_W'(1);
    repeat (3) @(negedge clk);
    chk(pulse == 0, "R11 reset state", pulse, 0);
    rst_ni = 1;
    repeat (4) @(negedge clk);
    chk(pulse == 0, "R11 after release", pulse, 0);

    // R1 bypass ratios in both modes
    for (int k = 0; k < 7; k++) run_cfg(0, k, 0, 1, "R1 fd bypass");
    run_cfg(1, 4, 0, 1, "R1 dm bypass");
    // R3 fixed divide, A ignored
    run_cfg(0, 0, 0, 5, "R3 fd");
    run_cfg(0, 2, 0, 3, "R3 fd");
    run_cfg(0, 3, 0, 4, "R3 fd a0");
    run_cfg(0, 3, 45, 4, "R3 fd a ignored");
    // R4 equivalent settings for N=12, A=0
    run_cfg(0, 1, 0, 6, "R4 eq12 fd");
    run_cfg(1, 1, 0, 6, "R4 eq12 dm2");
    run_cfg(1, 3, 0, 3, "R4 eq12 dm4");
    // R2 dual modulus
    run_cfg(1, 1, 1, 3, "R2 dm n7");
    run_cfg(1, 1, 2, 3, "R2 dm n8");
    run_cfg(1, 4, 6, 18, "R2 dm n150");
    run_cfg(1, 4, 7, 18, "R2 dm n151");
    run_cfg(1, 5, 7, 9, "R2 dm n151 alt");
    run_cfg(1, 6, 22, 84, "R2 dm n2710");
    // R5 R6 R7 illegal
    run_cfg(1, 3, 5, 5, "R5 a eq b");
    run_cfg(1, 3, 9, 5, "R5 a gt b");
    run_cfg(0, 3, 0, 2, "R6 b2");
    run_cfg(0, 3, 0, 0, "R6 b0");
    run_cfg(0, 7, 0, 4, "R6 code7");
    run_cfg(1, 0, 0, 4, "R6 dm code0");
    run_cfg(1, 2, 0, 4, "R6 dm code2");
    run_cfg(0, 3, 1, 1, "R7 bypass a");

    // R9 held reset stays quiet, then first pulse at N
    @(negedge clk); dm = 1; psel = 3'd3; a = A_W'(2); b = B_W'(5); srst = 1;
    quiet(50, "R9 held");
    srst = 0;
    gap(30, c); chk(c == 22, "R9 release", c, 22);

    // R8 illegal mid-run
    a = A_W'(7);
    @(negedge clk);
    chk(bad == 1, "R8 flag", bad, 1);
    quiet(60, "R8 quiet");
    a = A_W'(2);
    gap(30, c); chk(c == 22, "R8 restart", c, 22);

    // R10 sync request without enable ignored
    sen = 0; c = 0;
    while (c < 30) begin
      @(posedge clk); c++;
      @(negedge clk);
      if (c == 5) sreq = 1;
      if (c == 8) sreq = 0;
      if (pulse) break;
    end
    sreq = 0;
    chk(c == 22, "R10 no enable", c, 22);
    // R10 with enable resets
    sen = 1; c = 0;
    while (c < 8) begin
      @(posedge clk); c++;
      @(negedge clk);
      if (c == 5) sreq = 1;
    end
    sreq = 0;
    gap(30, c); chk(c == 22, "R10 enabled restart", c, 22);
    gap(30, c); chk(c == 22, "R12 spacing after sync", c, 22);
    sen = 0;

    // R12 random legal and illegal configs
    for (int k = 0; k < 30; k++) begin
      bit m = 1'($urandom % 2);
      int code, bv, av;
      int dmc[5] = '{1, 3, 4, 5, 6};
      code = m ? dmc[$urandom % 5] : int'($urandom % 7);
      bv = ($urandom % 6 == 0) ? 1 : 3 + int'($urandom % 18);
      av = (bv == 1) ? 0 : (m ? int'($urandom % (bv + 1)) : int'($urandom % 64));
      run_cfg(m, code, av, bv, "R12 random");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule